// File: doc/BRIEF.md
# Range-Clamped Servo Pulse Generator

This block drives two hobby-servo axes (pan and tilt) from one fast system clock. Each axis accepts a requested pulse width, counted in clock ticks, together with a one-cycle write strobe. The request is saturated in hardware into a window fixed per axis by parameters. Whatever value the controlling logic writes, the servo cannot be driven past the travel that the mechanics allow. The two windows may differ from each other and need not sit symmetrically around the centre.

Both axes share one free-running frame counter. With the default parameters the frame is 2,000,000 ticks, or 20 ms at 100 MHz. In each frame an axis output is high for exactly the saturated width and low for the rest. A new width is staged when it is written and is loaded into the comparator only at the frame boundary, so a pulse is never cut short or lengthened part-way through. The output comes straight from a flip-flop.

Top module: `servo_pwm_pair`

## Requirements
- R1: The frame counter counts from 0 up to FRAME_TICKS-1 and then returns to 0, so a pulse on either output starts exactly FRAME_TICKS cycles after the previous pulse on that output started.
- R2: In each frame an output is high for exactly W consecutive cycles and low for the rest, where W is the width in force for that frame. The high run starts one cycle after the counter returns to 0.
- R3: A request, read as an unsigned number, that is above the axis maximum (PAN_MAX or TILT_MAX) produces a pulse of exactly the maximum width.
- R4: A request below the axis minimum, zero included, produces a pulse of exactly the minimum width (PAN_MIN or TILT_MIN). A request inside the window is used unchanged.
- R5: Both outputs are low while reset is high. In the first frame after reset, both pulses are CENTER_TICKS wide.
- R6: A write that arrives while a pulse is in progress does not change the length of that pulse.
- R7: A write strobed during a frame sets the width of the next frame. If several writes fall in the same frame, the last one is used. A change on the request input while the strobe is low has no effect.
- R8: Each axis uses its own window. A write to one axis leaves the pulse width of the other axis unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pan_req | input | CMD_W | Requested pan pulse width in ticks, unsigned |
| pan_we | input | 1 | Strobe that captures pan_req |
| tilt_req | input | CMD_W | Requested tilt pulse width in ticks, unsigned |
| tilt_we | input | 1 | Strobe that captures tilt_req |
| pan_pwm | output | 1 | Registered pan servo pulse |
| tilt_pwm | output | 1 | Registered tilt servo pulse |

## Verification
A write reaches the staging register one edge after the strobe. It reaches the output only at the next counter wrap, and the output register adds one more cycle. The first affected high sample therefore comes one cycle after the counter wraps. The bench writes in the low part of a frame and then measures the whole next pulse, so every check is sampled on a falling clock edge once that latency has passed. For the mid-pulse write it counts the pulse that is already running, and it measures rise-to-rise distance for the frame length.

// File: rtl/servo_pwm_pkg.sv
package servo_pwm_pkg;

  localparam int AXIS_COUNT = 2;

  // Unsigned saturation of a requested width into [lo, hi].
  function automatic logic [31:0] saturate_ticks(input logic [31:0] req,
                                                 input logic [31:0] lo,
                                                 input logic [31:0] hi);
    if (req < lo) return lo;
    if (req > hi) return hi;
    return req;
  endfunction

endpackage

// File: rtl/servo_frame_counter.sv
module servo_frame_counter #(
  parameter int FRAME_TICKS = 2000000,
  parameter int CNT_W       = 21
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] tick,
  output logic             frame_last
);

  localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(FRAME_TICKS - 1);

  assign frame_last = (tick == LAST_TICK);

  always_ff @(posedge clk) begin
    if (rst)             tick <= '0;
    else if (frame_last) tick <= '0;
    else                 tick <= tick + 1'b1;
  end

  assert_tick_bound_R1: assert property (@(posedge clk) disable iff (rst)
    tick <= LAST_TICK);

  assert_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    frame_last |=> (tick == '0));

  assert_step_R1: assert property (@(posedge clk) disable iff (rst)
    !frame_last |=> (tick == $past(tick) + 1'b1));

endmodule

// File: rtl/servo_cmd_limiter.sv
module servo_cmd_limiter
  import servo_pwm_pkg::*;
#(
  parameter int CMD_W = 21,
  parameter int LO    = 100000,
  parameter int HI    = 200000,
  parameter int INIT  = 150000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CMD_W-1:0] req,
  input  logic             we,
  output logic [CMD_W-1:0] staged
);

  logic [31:0] limited;

  always_comb limited = saturate_ticks(32'(req), 32'(LO), 32'(HI));

  always_ff @(posedge clk) begin
    if (rst)     staged <= CMD_W'(INIT);
    else if (we) staged <= limited[CMD_W-1:0];
  end

  // R3 / R4: staged width always sits inside the window
  assert_staged_window_R3: assert property (@(posedge clk) disable iff (rst)
    (32'(staged) >= 32'(LO)) && (32'(staged) <= 32'(HI)));

  assert_low_request_R4: assert property (@(posedge clk) disable iff (rst)
    (we && (32'(req) < 32'(LO))) |=> (32'(staged) == 32'(LO)));

  assert_no_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(staged));

endmodule

// File: rtl/servo_pulse_channel.sv
module servo_pulse_channel #(
  parameter int CMD_W = 21,
  parameter int INIT  = 150000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CMD_W-1:0] tick,
  input  logic             frame_last,
  input  logic [CMD_W-1:0] staged,
  output logic             pwm
);

  logic [CMD_W-1:0] active_w;

  // Width loaded only as the counter wraps
  always_ff @(posedge clk) begin
    if (rst)             active_w <= CMD_W'(INIT);
    else if (frame_last) active_w <= staged;
  end

  always_ff @(posedge clk) begin
    if (rst) pwm <= 1'b0;
    else     pwm <= (tick < active_w);
  end

  assert_hold_mid_frame_R6: assert property (@(posedge clk) disable iff (rst)
    !frame_last |=> $stable(active_w));

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    ((tick != '0) && !pwm) |=> !pwm);

  assert_pulse_start_R2: assert property (@(posedge clk) disable iff (rst)
    ((tick == '0) && (active_w != '0)) |=> pwm);

  assert_reset_low_R5: assert property (@(posedge clk)
    rst |=> !pwm);

endmodule

// File: rtl/servo_pwm_pair.sv
module servo_pwm_pair
  import servo_pwm_pkg::*;
#(
  parameter int FRAME_TICKS  = 2000000,
  parameter int CMD_W        = 21,
  parameter int PAN_MIN      = 100000,
  parameter int PAN_MAX      = 200000,
  parameter int TILT_MIN     = 70000,
  parameter int TILT_MAX     = 190000,
  parameter int CENTER_TICKS = 150000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CMD_W-1:0] pan_req,
  input  logic             pan_we,
  input  logic [CMD_W-1:0] tilt_req,
  input  logic             tilt_we,
  output logic             pan_pwm,
  output logic             tilt_pwm
);

  logic [CMD_W-1:0] tick;
  logic             frame_last;

  logic [CMD_W-1:0] req_a    [AXIS_COUNT];
  logic             we_a     [AXIS_COUNT];
  logic [CMD_W-1:0] staged_a [AXIS_COUNT];
  logic             pwm_a    [AXIS_COUNT];

  assign req_a[0] = pan_req;
  assign req_a[1] = tilt_req;
  assign we_a[0]  = pan_we;
  assign we_a[1]  = tilt_we;
  assign pan_pwm  = pwm_a[0];
  assign tilt_pwm = pwm_a[1];

  servo_frame_counter #(
    .FRAME_TICKS(FRAME_TICKS),
    .CNT_W      (CMD_W)
  ) u_frame (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .frame_last(frame_last)
  );

  for (genvar g = 0; g < AXIS_COUNT; g++) begin : g_axis
    localparam int LO = (g == 0) ? PAN_MIN : TILT_MIN;
    localparam int HI = (g == 0) ? PAN_MAX : TILT_MAX;

    servo_cmd_limiter #(
      .CMD_W(CMD_W),
      .LO   (LO),
      .HI   (HI),
      .INIT (CENTER_TICKS)
    ) u_limit (
      .clk   (clk),
      .rst   (rst),
      .req   (req_a[g]),
      .we    (we_a[g]),
      .staged(staged_a[g])
    );

    servo_pulse_channel #(
      .CMD_W(CMD_W),
      .INIT (CENTER_TICKS)
    ) u_chan (
      .clk       (clk),
      .rst       (rst),
      .tick      (tick),
      .frame_last(frame_last),
      .staged    (staged_a[g]),
      .pwm       (pwm_a[g])
    );
  end

endmodule

// File: tb/test_servo_pwm_pair.sv
module test_servo_pwm_pair;

  localparam int F     = 64;
  localparam int W     = 8;
  localparam int P_LO  = 10;
  localparam int P_HI  = 40;
  localparam int T_LO  = 7;
  localparam int T_HI  = 38;
  localparam int CTR   = 20;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] pan_req = '0;
  logic         pan_we = 1'b0;
  logic [W-1:0] tilt_req = '0;
  logic         tilt_we = 1'b0;
  logic         pan_pwm;
  logic         tilt_pwm;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  servo_pwm_pair #(
    .FRAME_TICKS(F), .CMD_W(W),
    .PAN_MIN(P_LO), .PAN_MAX(P_HI),
    .TILT_MIN(T_LO), .TILT_MAX(T_HI),
    .CENTER_TICKS(CTR)
  ) i_servo_pwm_pair (
    .clk(clk), .rst(rst),
    .pan_req(pan_req), .pan_we(pan_we),
    .tilt_req(tilt_req), .tilt_we(tilt_we),
    .pan_pwm(pan_pwm), .tilt_pwm(tilt_pwm)
  );

  function automatic int expect_w(int axis, int v);
    int lo, hi;
    lo = (axis == 0) ? P_LO : T_LO;
    hi = (axis == 0) ? P_HI : T_HI;
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  function automatic logic out_of(int axis);
    return (axis == 0) ? pan_pwm : tilt_pwm;
  endfunction

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wait_rise(int axis);
    logic prev;
    prev = out_of(axis);
    forever begin
      @(negedge clk);
      if (out_of(axis) && !prev) break;
      prev = out_of(axis);
    end
  endtask

  // From a rise: count the high samples; ends on the first low sample.
  task automatic pulse_len(int axis, output int n);
    n = 1;
    forever begin
      @(negedge clk);
      if (!out_of(axis)) break;
      n++;
    end
  endtask

  task automatic measure(int axis, output int n);
    wait_rise(axis);
    pulse_len(axis, n);
  endtask

  task automatic write(int axis, int v);
    @(negedge clk);
    if (axis == 0) begin pan_req = W'(v); pan_we = 1'b1; end
    else           begin tilt_req = W'(v); tilt_we = 1'b1; end
    @(negedge clk);
    pan_we = 1'b0;
    tilt_we = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    int lowseen;
    // R5: outputs low during reset
    lowseen = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (pan_pwm || tilt_pwm) lowseen++;
    end
    check("R5 outputs low in reset", lowseen, 0);
    rst = 1'b0;

    // R5 / R2: first frame pulse is centre width on both axes
    fork
      begin int a; measure(0, a); check("R5 pan first width", a, CTR); end
      begin int b; measure(1, b); check("R5 tilt first width", b, CTR); end
    join

    // R1: frame length, rise to rise
    wait_rise(0);
    n = 1;
    forever begin
      @(negedge clk);
      if (pan_pwm && n > 1 && lowseen == 1) break;
      if (!pan_pwm) lowseen = 1;
      n++;
    end
    check("R1 pan frame length", n, F);

    // R2 / R3 / R4: exhaustive pan sweep
    for (int v = 0; v < 256; v++) begin
      write(0, v);
      measure(0, n);
      if (v > P_HI)      check("R3 pan above max", n, P_HI);
      else if (v < P_LO) check("R4 pan below min", n, P_LO);
      else               check("R2 pan in window", n, v);
    end

    // R8: tilt untouched by pan writes
    measure(1, n);
    check("R8 tilt unchanged by pan", n, CTR);

    // R2 / R3 / R4: exhaustive tilt sweep
    for (int v = 0; v < 256; v++) begin
      write(1, v);
      measure(1, n);
      check((v > T_HI) ? "R3 tilt above max" : (v < T_LO) ? "R4 tilt below min" : "R2 tilt in window",
            n, expect_w(1, v));
    end
    measure(0, n);
    check("R8 pan unchanged by tilt", n, P_HI);

    // R1: tilt frame length
    wait_rise(1);
    n = 1;
    lowseen = 0;
    forever begin
      @(negedge clk);
      if (tilt_pwm && lowseen == 1) break;
      if (!tilt_pwm) lowseen = 1;
      n++;
    end
    check("R1 tilt frame length", n, F);

    // R6: write during an active pulse does not shorten it
    wait_rise(0);
    pan_req = W'(P_LO);
    pan_we = 1'b1;
    n = 1;
    forever begin
      @(negedge clk);
      pan_we = 1'b0;
      if (!pan_pwm) break;
      n++;
    end
    check("R6 running pulse kept", n, P_HI);
    measure(0, n);
    check("R7 mid-pulse write next frame", n, P_LO);

    // R7: strobe low ignored
    @(negedge clk);
    pan_req = W'(33);
    measure(0, n);
    check("R7 no strobe ignored", n, P_LO);

    // R7: last write in a frame wins
    write(0, 12);
    write(0, 33);
    measure(0, n);
    check("R7 last write wins", n, 33);

    // R4: zero request on tilt
    write(1, 0);
    measure(1, n);
    check("R4 tilt zero request", n, T_LO);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule